// File: doc/BRIEF.md
# Read-Path SECDED Guard for Program Memory Fetches

This block sits on the fetch path between a non-volatile program store and the refill port of an instruction cache. Every stored word is 64 data bits plus an 8-bit check byte, so each fetched beat is 72 bits wide. On each fetch the block recomputes the syndrome from the returned bits. It repairs any single flipped bit in the copy sent to the cache and marks any two-bit upset as uncorrectable. It never writes a repair back to storage. A combinational encoder on the write side produces the check byte for each word as a row is programmed. A 256-byte row therefore carries 32 check bytes.

Repaired fetches and uncorrectable fetches are logged in two independent fault records. Each record holds a captured word address, a valid flag and an interrupt enable. A flag stays set, and its address frozen, until software clears it with a write-one-to-clear access. The gated records are merged into one level-sensitive interrupt request. A configuration input turns the whole check off. The fetched data then passes through raw, and nothing is flagged or logged.

Top module: `secded_read_guard`

## Requirements
- R1: The write-side encoder maps data to a check byte. Each data bit j is placed at codeword position P(j), where P counts 3, 5, 6, 7, 9, ... and skips every power of two. Check bit i (i = 0..6) is the XOR of the data bits whose P(j) has bit i set. Check bit 7 makes the XOR of all 72 bits zero. All-zero data encodes to 8'h00, and the encoding is linear: enc(a^b) = enc(a)^enc(b).
- R2: A fetch is presented with `fetch_vld`. Its result appears on `resp_*` after the next rising clock edge, with `resp_vld` high for exactly that cycle. A clean word, with check bits in `fetch_word[71:64]`, returns its data unchanged and with both flags low.
- R3: With checking on, a word with any one of its 72 bits inverted returns the original data with `resp_fixed`=1 and `resp_fatal`=0. This includes an inverted check bit.
- R4: With checking on, a word with any two of its bits inverted returns `resp_fatal`=1 and `resp_fixed`=0. The data is returned exactly as received.
- R5: With `chk_on`=0, fetched data passes through raw, both flags stay 0 and neither record is written.
- R6: A repaired fetch sets `fix_seen` and captures `fetch_addr` into `fix_addr`. An uncorrectable fetch does the same into `bad_seen`/`bad_addr`. Both appear one edge after the fetch.
- R7: While a record's flag is set, later events of the same kind leave its captured address unchanged.
- R8: A CSR write (`csr_we`) targets the fix record when `csr_sel`=0 and the bad record when `csr_sel`=1. `csr_clr`=1 clears that record's flag. If a clear and a new event reach the same record in the same cycle, the event is captured.
- R9: The same CSR write loads that record's interrupt enable from `csr_ien`. `irq` is high exactly while some record has its flag and its enable both set.
- R10: After reset both flags and both enables are 0, and `resp_vld`, `resp_fixed`, `resp_fatal` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chk_on | input | 1 | 1 enables checking and correction |
| prog_data | input | 64 | Data word being programmed |
| prog_chk | output | 8 | Check byte for `prog_data` |
| fetch_vld | input | 1 | Fetch beat present |
| fetch_addr | input | 16 | Word address of the fetch |
| fetch_word | input | 72 | Fetched beat, check byte in [71:64] |
| resp_vld | output | 1 | Response present |
| resp_data | output | 64 | Data toward the cache |
| resp_fixed | output | 1 | Single-bit error was repaired |
| resp_fatal | output | 1 | Uncorrectable error detected |
| csr_we | input | 1 | Record control write strobe |
| csr_sel | input | 1 | 0 selects the fix record, 1 the bad record |
| csr_clr | input | 1 | Write-one-to-clear of the selected flag |
| csr_ien | input | 1 | New interrupt enable of the selected record |
| fix_seen | output | 1 | Fix record flag |
| fix_addr | output | 16 | Address of the first logged repair |
| bad_seen | output | 1 | Bad record flag |
| bad_addr | output | 16 | Address of the first logged uncorrectable fetch |
| irq | output | 1 | Merged interrupt request |

## Verification
A wrong syndrome or position map shows at the response one edge after the fetch. The data comes back with a bit still wrong, or flipped at the wrong place, or the class flag is wrong. Walking every single-bit position and several double-bit pairs exposes it on the first affected position. A record that overwrites or loses its held address, or ignores a clear, shows on the address and flag ports one edge after the offending event. It also shows on `irq` in the same cycle as the flag.

// File: rtl/secded_pkg.sv
// Shared constants and helpers for the SECDED read guard.
// Assumes a single-error-correcting Hamming code with check bits at the
// power-of-two codeword positions and one extra overall parity bit.
package secded_pkg;

    localparam int SD_DATA_W = 64;
    localparam int SD_ADDR_W = 16;

    // Number of Hamming check bits needed to cover DATA_W data bits.
    function automatic int ham_bits(input int data_w);
        int r;
        r = 1;
        while ((1 << r) < data_w + r + 1) r++;
        return r;
    endfunction

    // Codeword position of data bit j: the j-th position >= 3 that is not a power of two.
    function automatic int data_pos(input int j);
        int pos;
        int cnt;
        pos = 2;
        cnt = -1;
        while (cnt < j) begin
            pos++;
            if ((pos & (pos - 1)) != 0) cnt++;
        end
        return pos;
    endfunction

endpackage

// File: rtl/secded_encoder.sv
// Combinational check-byte generator.
// Each set data bit XORs its codeword position into the Hamming field.
// The top bit balances the parity of the whole codeword to zero.
// Assumes CHK_W = HAM_W + 1.
module secded_encoder #(
    parameter int DATA_W = secded_pkg::SD_DATA_W,
    parameter int HAM_W  = secded_pkg::ham_bits(DATA_W),
    localparam int CHK_W = HAM_W + 1
) (
    input  logic [DATA_W-1:0] data,
    output logic [CHK_W-1:0]  check
);

    logic [HAM_W-1:0] ham;

    // Fold every set data bit's position into the Hamming field.
    always_comb begin
        ham = '0;
        for (int j = 0; j < DATA_W; j++) begin
            if (data[j]) ham = ham ^ HAM_W'(secded_pkg::data_pos(j));
        end
    end

    // Append the overall parity bit.
    always_comb begin
        check = {(^data) ^ (^ham), ham};
    end

    // The full codeword must have even parity.
    always_comb begin
        AST_EVEN_CODEWORD: assert ((^{check, data}) == 1'b0 || $isunknown(data)); // R1
    end

endmodule

// File: rtl/secded_decoder.sv
// Read-path syndrome check and single-bit repair, one register stage.
// Classifies each fetch as clean, repaired or uncorrectable, and offers
// single-cycle event pulses for the fault records.
// Assumes the fetch word holds the check byte above the data.
module secded_decoder #(
    parameter int DATA_W = secded_pkg::SD_DATA_W,
    parameter int HAM_W  = secded_pkg::ham_bits(DATA_W),
    localparam int CHK_W  = HAM_W + 1,
    localparam int CODE_W = DATA_W + CHK_W,
    localparam int POS_MAX = DATA_W + HAM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_on,
    input  logic              in_vld,
    input  logic [CODE_W-1:0] in_word,
    output logic              ev_fixed,
    output logic              ev_fatal,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_data,
    output logic              out_fixed,
    output logic              out_fatal
);

    logic [DATA_W-1:0] rx_data;
    logic [CHK_W-1:0]  rx_chk;
    logic [CHK_W-1:0]  calc_chk;
    logic [HAM_W-1:0]  syn;
    logic              par_odd;
    logic              syn_zero;
    logic              syn_inrange;
    logic              is_fixed;
    logic              is_fatal;
    logic [DATA_W-1:0] fixed_data;

    assign rx_data = in_word[DATA_W-1:0];
    assign rx_chk  = in_word[CODE_W-1:DATA_W];

    // Recompute the check byte from the received data.
    secded_encoder #(.DATA_W(DATA_W), .HAM_W(HAM_W)) i_recalc (
        .data  (rx_data),
        .check (calc_chk)
    );

    // Build the syndrome and the overall parity of the received codeword.
    always_comb begin
        syn         = calc_chk[HAM_W-1:0] ^ rx_chk[HAM_W-1:0];
        par_odd     = ^in_word;
        syn_zero    = (syn == '0);
        syn_inrange = (int'(syn) <= POS_MAX);
    end

    // Classify: odd parity with a reachable position is repairable.
    always_comb begin
        is_fixed = chk_on && par_odd && (syn_zero || syn_inrange);
        is_fatal = chk_on && ((!par_odd && !syn_zero) || (par_odd && !syn_inrange));
    end

    // Invert the data bit the syndrome points at, if any.
    always_comb begin
        fixed_data = rx_data;
        if (is_fixed) begin
            for (int j = 0; j < DATA_W; j++) begin
                if (syn == HAM_W'(secded_pkg::data_pos(j))) fixed_data[j] = ~rx_data[j];
            end
        end
    end

    assign ev_fixed = in_vld && is_fixed;
    assign ev_fatal = in_vld && is_fatal;

    // Register the response toward the cache.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld   <= 1'b0;
            out_data  <= '0;
            out_fixed <= 1'b0;
            out_fatal <= 1'b0;
        end else begin
            out_vld   <= in_vld;
            out_fixed <= ev_fixed;
            out_fatal <= ev_fatal;
            if (in_vld) out_data <= fixed_data;
        end
    end

    AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_fixed && out_fatal)); // R3
    AST_RESP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld); // R2
    AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !chk_on) |=> (!out_fixed && !out_fatal)); // R5

endmodule

// File: rtl/secded_fault_log.sv
// One fault record: sticky flag, frozen address and interrupt enable.
// The address is captured only when the flag is free or is being cleared
// in the same cycle; an event beats a simultaneous clear.
module secded_fault_log #(
    parameter int ADDR_W = secded_pkg::SD_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic              clr,
    input  logic              ien_we,
    input  logic              ien_d,
    output logic              seen,
    output logic [ADDR_W-1:0] addr,
    output logic              req
);

    logic ien;
    logic take;

    assign take = ev && (!seen || clr);

    // Sticky flag with write-one-to-clear; an event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= (seen && !clr) || ev;
    end

    // Capture the address of the first event while the flag is free.
    always_ff @(posedge clk) begin
        if (!rst_n)    addr <= '0;
        else if (take) addr <= ev_addr;
    end

    // Interrupt enable, loaded by the CSR write.
    always_ff @(posedge clk) begin
        if (!rst_n)      ien <= 1'b0;
        else if (ien_we) ien <= ien_d;
    end

    assign req = seen && ien;

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !clr) |=> (seen && $stable(addr))); // R7
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> seen); // R6
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ev) |=> !seen); // R8

endmodule

// File: rtl/secded_read_guard.sv
// Top of the read-path SECDED guard: write-side encoder, read-side
// decoder, and two fault records (repairs, uncorrectable) merged into
// one level interrupt. Assumes one fetch beat per cycle at most.
module secded_read_guard #(
    parameter int DATA_W = secded_pkg::SD_DATA_W,
    parameter int ADDR_W = secded_pkg::SD_ADDR_W,
    localparam int HAM_W  = secded_pkg::ham_bits(DATA_W),
    localparam int CHK_W  = HAM_W + 1,
    localparam int CODE_W = DATA_W + CHK_W,
    localparam int NREC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_on,
    input  logic [DATA_W-1:0] prog_data,
    output logic [CHK_W-1:0]  prog_chk,
    input  logic              fetch_vld,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [CODE_W-1:0] fetch_word,
    output logic              resp_vld,
    output logic [DATA_W-1:0] resp_data,
    output logic              resp_fixed,
    output logic              resp_fatal,
    input  logic              csr_we,
    input  logic              csr_sel,
    input  logic              csr_clr,
    input  logic              csr_ien,
    output logic              fix_seen,
    output logic [ADDR_W-1:0] fix_addr,
    output logic              bad_seen,
    output logic [ADDR_W-1:0] bad_addr,
    output logic              irq
);

    logic              ev_fixed;
    logic              ev_fatal;
    logic [NREC-1:0]   rec_ev;
    logic [NREC-1:0]   rec_seen;
    logic [NREC-1:0]   rec_req;
    logic [ADDR_W-1:0] rec_addr [NREC];

    // Write-side check byte generation.
    secded_encoder #(.DATA_W(DATA_W), .HAM_W(HAM_W)) i_prog_enc (
        .data  (prog_data),
        .check (prog_chk)
    );

    // Read-side syndrome check and repair.
    secded_decoder #(.DATA_W(DATA_W), .HAM_W(HAM_W)) i_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .chk_on    (chk_on),
        .in_vld    (fetch_vld),
        .in_word   (fetch_word),
        .ev_fixed  (ev_fixed),
        .ev_fatal  (ev_fatal),
        .out_vld   (resp_vld),
        .out_data  (resp_data),
        .out_fixed (resp_fixed),
        .out_fatal (resp_fatal)
    );

    assign rec_ev = {ev_fatal, ev_fixed};

    // One record per event class; index 0 repairs, index 1 uncorrectable.
    for (genvar k = 0; k < NREC; k++) begin : g_rec
        logic sel_hit;
        assign sel_hit = csr_we && (int'(csr_sel) == k);
        secded_fault_log #(.ADDR_W(ADDR_W)) i_log (
            .clk     (clk),
            .rst_n   (rst_n),
            .ev      (rec_ev[k]),
            .ev_addr (fetch_addr),
            .clr     (sel_hit && csr_clr),
            .ien_we  (sel_hit),
            .ien_d   (csr_ien),
            .seen    (rec_seen[k]),
            .addr    (rec_addr[k]),
            .req     (rec_req[k])
        );
    end

    assign fix_seen = rec_seen[0];
    assign fix_addr = rec_addr[0];
    assign bad_seen = rec_seen[1];
    assign bad_addr = rec_addr[1];
    assign irq      = |rec_req;

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (fix_seen || bad_seen)); // R9

endmodule

// File: tb/test_secded_read_guard.sv
module test_secded_read_guard;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        chk_on;
    logic [63:0] prog_data;
    logic [7:0]  prog_chk;
    logic        fetch_vld;
    logic [15:0] fetch_addr;
    logic [71:0] fetch_word;
    logic        resp_vld;
    logic [63:0] resp_data;
    logic        resp_fixed, resp_fatal;
    logic        csr_we, csr_sel, csr_clr, csr_ien;
    logic        fix_seen, bad_seen, irq;
    logic [15:0] fix_addr, bad_addr;

    int n_run = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    secded_read_guard i_secded_read_guard (
        .clk(clk), .rst_n(rst_n), .chk_on(chk_on),
        .prog_data(prog_data), .prog_chk(prog_chk),
        .fetch_vld(fetch_vld), .fetch_addr(fetch_addr), .fetch_word(fetch_word),
        .resp_vld(resp_vld), .resp_data(resp_data),
        .resp_fixed(resp_fixed), .resp_fatal(resp_fatal),
        .csr_we(csr_we), .csr_sel(csr_sel), .csr_clr(csr_clr), .csr_ien(csr_ien),
        .fix_seen(fix_seen), .fix_addr(fix_addr),
        .bad_seen(bad_seen), .bad_addr(bad_addr), .irq(irq)
    );

    localparam int NV = 10;
    localparam logic [63:0] V_DATA [NV] = '{
        64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF,
        64'hDEAD_BEEF_CAFE_F00D, 64'h8000_0000_0000_0001, 64'h5555_AAAA_5555_AAAA,
        64'h0F0F_F0F0_3C3C_C3C3, 64'h1111_2222_4444_8888, 64'hA5A5_5A5A_0000_FFFF,
        64'h7FFF_FFFF_FFFF_FFFE};
    // Bit indices into the 72-bit word to invert; -1 means none.
    localparam int V_F1 [NV] = '{-1, 0, 63, 64, 71, -1, 3, 0, 70, 30};
    localparam int V_F2 [NV] = '{-1, -1, -1, -1, -1, -1, 40, 71, 64, 31};

    task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [71:0] encode_tb(input logic [63:0] d);
        return 72'h0;
    endfunction

    task automatic get_chk(input logic [63:0] d, output logic [7:0] c);
        prog_data = d;
        #1;
        c = prog_chk;
    endtask

    task automatic fetch(input logic [71:0] w, input logic [15:0] a);
        @(negedge clk);
        fetch_vld  = 1'b1;
        fetch_word = w;
        fetch_addr = a;
        @(negedge clk);
        fetch_vld  = 1'b0;
    endtask

    task automatic csr(input bit sel, input bit clr, input bit ien);
        @(negedge clk);
        csr_we = 1'b1; csr_sel = sel; csr_clr = clr; csr_ien = ien;
        @(negedge clk);
        csr_we = 1'b0; csr_clr = 1'b0;
    endtask

    initial begin
        #200000;
        n_run++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        logic [7:0]  c, ca, cb, cab;
        logic [71:0] w;
        rst_n = 1'b0; chk_on = 1'b1; prog_data = '0;
        fetch_vld = 1'b0; fetch_addr = '0; fetch_word = '0;
        csr_we = 1'b0; csr_sel = 1'b0; csr_clr = 1'b0; csr_ien = 1'b0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!resp_vld && !resp_fixed && !resp_fatal && !fix_seen && !bad_seen && !irq,
            "R10 reset", {resp_vld, resp_fixed, resp_fatal, fix_seen, bad_seen, irq}, 72'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: zero data, linearity, even codeword parity
        get_chk(64'h0, c);
        chk(c == 8'h00, "R1 zero", c, 8'h00);
        get_chk(64'h0123_4567_89AB_CDEF, ca);
        get_chk(64'hF0E1_D2C3_B4A5_9687, cb);
        get_chk(64'h0123_4567_89AB_CDEF ^ 64'hF0E1_D2C3_B4A5_9687, cab);
        chk(cab == (ca ^ cb), "R1 linear", cab, ca ^ cb);
        chk((^{ca, 64'h0123_4567_89AB_CDEF}) == 1'b0, "R1 parity", ca, ca);
        get_chk(64'h1, c);
        chk(c == 8'h83, "R1 bit0 at position 3", c, 8'h83);

        // R2 R3 R4 R6: vector table
        for (int v = 0; v < NV; v++) begin
            int nf;
            get_chk(V_DATA[v], c);
            w = {c, V_DATA[v]};
            nf = 0;
            if (V_F1[v] >= 0) begin w[V_F1[v]] = ~w[V_F1[v]]; nf++; end
            if (V_F2[v] >= 0) begin w[V_F2[v]] = ~w[V_F2[v]]; nf++; end
            fetch(w, 16'(16'h100 + v));
            chk(resp_vld, "R2 resp_vld", resp_vld, 1);
            if (nf < 2) begin
                chk(resp_data == V_DATA[v], "R2/R3 data", resp_data, V_DATA[v]);
                chk(resp_fixed == (nf == 1) && !resp_fatal, "R3 flags",
                    {resp_fixed, resp_fatal}, {(nf == 1), 1'b0});
            end else begin
                chk(resp_data == w[63:0], "R4 raw data", resp_data, w[63:0]);
                chk(resp_fatal && !resp_fixed, "R4 flags", {resp_fixed, resp_fatal}, 2'b01);
            end
            chk(fix_seen == (nf == 1) && bad_seen == (nf == 2), "R6 records",
                {fix_seen, bad_seen}, {(nf == 1), (nf == 2)});
            if (nf == 1) chk(fix_addr == 16'(16'h100 + v), "R6 fix_addr", fix_addr, 16'h100 + v);
            if (nf == 2) chk(bad_addr == 16'(16'h100 + v), "R6 bad_addr", bad_addr, 16'h100 + v);
            csr(1'b0, 1'b1, 1'b0);
            csr(1'b1, 1'b1, 1'b0);
        end

        // R3: every single bit position of one word
        get_chk(64'h3C5A_96E1_0F87_D24B, c);
        for (int b = 0; b < 72; b++) begin
            w = {c, 64'h3C5A_96E1_0F87_D24B};
            w[b] = ~w[b];
            fetch(w, 16'h0);
            chk(resp_data == 64'h3C5A_96E1_0F87_D24B && resp_fixed && !resp_fatal,
                $sformatf("R3 flip bit %0d", b), resp_data, 64'h3C5A_96E1_0F87_D24B);
        end
        csr(1'b0, 1'b1, 1'b0);

        // R5: checking off passes raw data, no flags, no records
        chk_on = 1'b0;
        get_chk(64'h1234, c);
        w = {c, 64'h1234};
        w[5] = ~w[5]; w[9] = ~w[9];
        fetch(w, 16'h55);
        chk(resp_data == w[63:0] && !resp_fixed && !resp_fatal && !fix_seen && !bad_seen,
            "R5 bypass", {resp_fixed, resp_fatal, fix_seen, bad_seen}, 0);
        chk_on = 1'b1;

        // R7: held address while flag set
        get_chk(64'hABCD, c);
        w = {c, 64'hABCD}; w[7] = ~w[7];
        fetch(w, 16'h0AA);
        fetch(w, 16'h0BB);
        chk(fix_seen && fix_addr == 16'h0AA, "R7 hold fix", fix_addr, 16'h0AA);
        w[8] = ~w[8];
        fetch(w, 16'h0C1);
        fetch(w, 16'h0C2);
        chk(bad_seen && bad_addr == 16'h0C1, "R7 hold bad", bad_addr, 16'h0C1);

        // R9: interrupt gating
        chk(!irq, "R9 irq masked", irq, 0);
        csr(1'b0, 1'b0, 1'b1);
        chk(irq, "R9 irq fix enabled", irq, 1);
        csr(1'b0, 1'b1, 1'b1);
        chk(!fix_seen && !irq && bad_seen, "R8/R9 clear fix", {fix_seen, irq, bad_seen}, 3'b001);
        csr(1'b1, 1'b0, 1'b1);
        chk(irq, "R9 irq bad enabled", irq, 1);
        csr(1'b1, 1'b1, 1'b0);
        chk(!bad_seen && !irq, "R8 clear bad", {bad_seen, irq}, 0);

        // R8: clear and event in the same cycle -> event captured
        w = {c, 64'hABCD}; w[2] = ~w[2];
        fetch(w, 16'h111);
        @(negedge clk);
        fetch_vld = 1'b1; fetch_word = w; fetch_addr = 16'h222;
        csr_we = 1'b1; csr_sel = 1'b0; csr_clr = 1'b1; csr_ien = 1'b0;
        @(negedge clk);
        fetch_vld = 1'b0; csr_we = 1'b0; csr_clr = 1'b0;
        chk(fix_seen && fix_addr == 16'h222, "R8 event beats clear", fix_addr, 16'h222);

        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

endmodule